// File: doc/BRIEF.md
# Tagged Coefficient Input and Run-Length Expander

This block sits at the front of a block-transform video decoder. It takes a byte stream in which every byte comes with a 4-bit tag that says what the byte means. Header bytes are latched into registers: group number, macroblock number, control decisions, quantizer value, the two motion-vector components and the current sub-block number. Zero-run bytes and coefficient-level bytes are expanded into exactly 64 signed 8-bit levels for one 8x8 block. The levels are reordered from zig-zag scan order to row-major order, and the result is presented as one wide bus with a one-cycle ready pulse.

A control-decisions byte opens each macroblock and resets the expander. When its skip bit is set, the block freezes until the next control byte arrives. The macroblock that follows a cleared skip is flagged as the first of a new frame. Bytes are taken only on clock edges where `in_valid_i` is high.

Top module: `coef_rle_expander`

## Requirements
- R1: After reset, every header output, `frame_first_o`, `blk_ready_o` and `run_err_o` are 0.
- R2: An accepted byte with tag 0000 loads `grp_num_o` from data bits 3:0. Tag 0001 loads `mb_num_o` from bits 5:0. Tag 0011 loads `quant_o` from bits 4:0. Tags 0100 and 0101 load `mv_x_o` and `mv_y_o` from the whole byte. Tag 0111 loads `sub_num_o` from bits 2:0. Each new value is visible in the cycle after the sampling edge.
- R3: Tag 0010 is the control byte. It drives the flags from these data bits: bit 0 to `fixed_mb_o`, bit 1 to `inter_o`, bit 2 to `filter_o`, bit 3 to `mc_o` and bit 6 to `skip_o`. It also closes any open block (emitting it), empties the expander and clears `run_err_o`.
- R4: Bytes with tag 0110, tags 1010 to 1110, tag 1111, and any cycle with `in_valid_i` low change no output and produce no block.
- R5: While `skip_o` is 1, every byte except a control byte is ignored: headers hold and no block is emitted.
- R6: `frame_first_o` becomes 1 with the first non-skip control byte after reset or after a skip control byte. It becomes 0 with any later control byte.
- R7: A sub-block byte (tag 0111) opens a block. Within an open block, a level byte (tag 1001) is placed at the next zig-zag position, and a run byte (tag 1000) of value N skips N positions, leaving zeros there. The 64th position filled by a level emits the block: `blk_ready_o` pulses one cycle after the sampling edge. The level at row r, column c sits at `blk_coef_o[(8*r+c)*8 +: 8]`. The scan starts at (0,0) and runs along the anti-diagonals: it moves up and to the right on even diagonals and down and to the left on odd ones.
- R8: A sub-block or control byte that arrives while a block is open emits that block with every unfilled position zero, even if no level arrived at all. `blk_sub_o` carries the sub-block number of the emitted block.
- R9: A run that ends exactly at position 64 emits the block with `run_err_o` left at 0. A run that would go past position 64 is truncated: the block is emitted, and `run_err_o` goes to 1 in the same cycle as the ready pulse. It stays at 1 until the next accepted sub-block or control byte.
- R10: Run and level bytes that arrive while no block is open are ignored. This covers the time after the block has been emitted and before the next sub-block byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Byte strobe |
| mode_i | input | 4 | Tag for the byte |
| data_i | input | 8 | Byte payload |
| grp_num_o | output | 4 | Group number |
| mb_num_o | output | 6 | Macroblock number |
| quant_o | output | 5 | Quantizer value |
| mv_x_o | output | 8 | Horizontal motion vector |
| mv_y_o | output | 8 | Vertical motion vector |
| sub_num_o | output | 3 | Current sub-block number |
| fixed_mb_o | output | 1 | Unchanged-macroblock flag |
| inter_o | output | 1 | Inter coding flag |
| filter_o | output | 1 | Loop filter flag |
| mc_o | output | 1 | Motion compensation flag |
| skip_o | output | 1 | Skip picture active |
| frame_first_o | output | 1 | Macroblock begins a frame |
| blk_ready_o | output | 1 | One-cycle pulse: block valid |
| blk_sub_o | output | 3 | Sub-block number of the emitted block |
| blk_coef_o | output | 512 | 64 levels in row-major order |
| run_err_o | output | 1 | Run overflow flag |

## Verification
The bench checks that the zig-zag reordering matches an order it builds independently by walking the diagonals. A wrong step rule would scatter distinct levels onto the wrong raster positions. It exercises runs that end exactly at position 64 and runs that go past it. A design with an off-by-one limit would either raise a false error or write past the block. It checks blocks flushed early by a sub-block or control byte, including blocks that received no level at all. A design that lost these would drop blocks or leave stale levels in them. Finally, it sends header, level and sub-block bytes during skip and after a block has closed. A design that failed to gate these would update the headers or emit blocks nobody asked for.

// File: rtl/rle_pkg.sv
package rle_pkg;

  localparam logic [3:0] TAG_GRP   = 4'b0000;
  localparam logic [3:0] TAG_MB    = 4'b0001;
  localparam logic [3:0] TAG_CTRL  = 4'b0010;
  localparam logic [3:0] TAG_QUANT = 4'b0011;
  localparam logic [3:0] TAG_MVX   = 4'b0100;
  localparam logic [3:0] TAG_MVY   = 4'b0101;
  localparam logic [3:0] TAG_SUB   = 4'b0111;
  localparam logic [3:0] TAG_RUN   = 4'b1000;
  localparam logic [3:0] TAG_LVL   = 4'b1001;

  typedef struct packed {
    logic grp;
    logic mb;
    logic ctrl;
    logic quant;
    logic mvx;
    logic mvy;
    logic sub;
    logic run;
    logic lvl;
  } tag_stb_t;

  // zig-zag scan index -> row-major index for a dim x dim block
  function automatic int zz_to_raster(input int k, input int dim);
    int r;
    int c;
    r = 0;
    c = 0;
    for (int i = 0; i < dim * dim; i++) begin
      if (i < k) begin
        if (((r + c) % 2) == 0) begin
          if (c == dim - 1) r = r + 1;
          else if (r == 0) c = c + 1;
          else begin r = r - 1; c = c + 1; end
        end else begin
          if (r == dim - 1) c = c + 1;
          else if (c == 0) r = r + 1;
          else begin r = r + 1; c = c - 1; end
        end
      end
    end
    return r * dim + c;
  endfunction

endpackage

// File: rtl/tag_decoder.sv
module tag_decoder
  import rle_pkg::*;
(
  input  logic       in_valid_i,
  input  logic [3:0] mode_i,
  input  logic       skip_i,
  output tag_stb_t   stb_o
);

  logic take;

  // control bytes always pass; everything else is frozen by skip
  assign take = in_valid_i && !skip_i;

  always_comb begin
    stb_o       = '0;
    stb_o.ctrl  = in_valid_i && (mode_i == TAG_CTRL);
    stb_o.grp   = take && (mode_i == TAG_GRP);
    stb_o.mb    = take && (mode_i == TAG_MB);
    stb_o.quant = take && (mode_i == TAG_QUANT);
    stb_o.mvx   = take && (mode_i == TAG_MVX);
    stb_o.mvy   = take && (mode_i == TAG_MVY);
    stb_o.sub   = take && (mode_i == TAG_SUB);
    stb_o.run   = take && (mode_i == TAG_RUN);
    stb_o.lvl   = take && (mode_i == TAG_LVL);
  end

endmodule

// File: rtl/hdr_regs.sv
module hdr_regs
  import rle_pkg::*;
#(
  parameter int DW    = 8,
  parameter int GRP_W = 4,
  parameter int MB_W  = 6,
  parameter int Q_W   = 5,
  parameter int SUB_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tag_stb_t         stb_i,
  input  logic [DW-1:0]    data_i,
  output logic [GRP_W-1:0] grp_num_o,
  output logic [MB_W-1:0]  mb_num_o,
  output logic [Q_W-1:0]   quant_o,
  output logic [DW-1:0]    mv_x_o,
  output logic [DW-1:0]    mv_y_o,
  output logic [SUB_W-1:0] sub_num_o,
  output logic             fixed_mb_o,
  output logic             inter_o,
  output logic             filter_o,
  output logic             mc_o,
  output logic             skip_o,
  output logic             frame_first_o
);

  logic frame_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_num_o     <= '0;
      mb_num_o      <= '0;
      quant_o       <= '0;
      mv_x_o        <= '0;
      mv_y_o        <= '0;
      sub_num_o     <= '0;
      fixed_mb_o    <= 1'b0;
      inter_o       <= 1'b0;
      filter_o      <= 1'b0;
      mc_o          <= 1'b0;
      skip_o        <= 1'b0;
      frame_first_o <= 1'b0;
      frame_pend_q  <= 1'b1;
    end else begin
      if (stb_i.grp)   grp_num_o <= data_i[GRP_W-1:0];
      if (stb_i.mb)    mb_num_o  <= data_i[MB_W-1:0];
      if (stb_i.quant) quant_o   <= data_i[Q_W-1:0];
      if (stb_i.mvx)   mv_x_o    <= data_i;
      if (stb_i.mvy)   mv_y_o    <= data_i;
      if (stb_i.sub)   sub_num_o <= data_i[SUB_W-1:0];
      if (stb_i.ctrl) begin
        fixed_mb_o <= data_i[0];
        inter_o    <= data_i[1];
        filter_o   <= data_i[2];
        mc_o       <= data_i[3];
        skip_o     <= data_i[6];
        if (data_i[6]) begin
          frame_pend_q  <= 1'b1;
          frame_first_o <= 1'b0;
        end else begin
          frame_first_o <= frame_pend_q;
          frame_pend_q  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/run_expander.sv
module run_expander
  import rle_pkg::*;
#(
  parameter int DW      = 8,
  parameter int BLK_DIM = 8,
  parameter int SUB_W   = 3,
  localparam int NCOEF  = BLK_DIM * BLK_DIM,
  localparam int IW     = $clog2(NCOEF),
  localparam int PW     = $clog2(NCOEF + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctl_stb_i,
  input  logic                sub_stb_i,
  input  logic                run_stb_i,
  input  logic                lvl_stb_i,
  input  logic [DW-1:0]       data_i,
  input  logic [SUB_W-1:0]    cur_sub_i,
  output logic                blk_ready_o,
  output logic [SUB_W-1:0]    blk_sub_o,
  output logic [NCOEF*DW-1:0] blk_coef_o,
  output logic                run_err_o
);

  localparam logic [DW:0] NC_W = (DW + 1)'(NCOEF);

  logic [DW-1:0] zbuf_q [NCOEF];
  logic [DW-1:0] zbuf_wr[NCOEF];
  logic [DW-1:0] snap_q [NCOEF];
  logic [PW-1:0] pos_q;
  logic          open_q;
  logic [DW:0]   run_end;

  assign run_end = {{(DW + 1 - PW){1'b0}}, pos_q} + {1'b0, data_i};

  always_comb begin
    for (int k = 0; k < NCOEF; k++) zbuf_wr[k] = zbuf_q[k];
    zbuf_wr[pos_q[IW-1:0]] = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NCOEF; k++) begin
        zbuf_q[k] <= '0;
        snap_q[k] <= '0;
      end
      pos_q       <= '0;
      open_q      <= 1'b0;
      blk_ready_o <= 1'b0;
      blk_sub_o   <= '0;
      run_err_o   <= 1'b0;
    end else begin
      blk_ready_o <= 1'b0;
      if (ctl_stb_i || sub_stb_i) begin
        if (open_q) begin
          for (int k = 0; k < NCOEF; k++) snap_q[k] <= zbuf_q[k];
          blk_sub_o   <= cur_sub_i;
          blk_ready_o <= 1'b1;
        end
        for (int k = 0; k < NCOEF; k++) zbuf_q[k] <= '0;
        pos_q     <= '0;
        open_q    <= sub_stb_i;
        run_err_o <= 1'b0;
      end else if (open_q && run_stb_i) begin
        if (run_end >= NC_W) begin
          // run fills or overruns the block: close it
          for (int k = 0; k < NCOEF; k++) begin
            snap_q[k] <= zbuf_q[k];
            zbuf_q[k] <= '0;
          end
          blk_sub_o   <= cur_sub_i;
          blk_ready_o <= 1'b1;
          pos_q       <= '0;
          open_q      <= 1'b0;
          if (run_end > NC_W) run_err_o <= 1'b1;
        end else begin
          pos_q <= run_end[PW-1:0];
        end
      end else if (open_q && lvl_stb_i) begin
        if (pos_q == PW'(NCOEF - 1)) begin
          for (int k = 0; k < NCOEF; k++) begin
            snap_q[k] <= zbuf_wr[k];
            zbuf_q[k] <= '0;
          end
          blk_sub_o   <= cur_sub_i;
          blk_ready_o <= 1'b1;
          pos_q       <= '0;
          open_q      <= 1'b0;
        end else begin
          zbuf_q[pos_q[IW-1:0]] <= data_i;
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  // scan order -> raster order is pure wiring
  for (genvar k = 0; k < NCOEF; k++) begin : g_map
    localparam int RI = zz_to_raster(k, BLK_DIM);
    assign blk_coef_o[RI*DW +: DW] = snap_q[k];
  end

endmodule

// File: rtl/coef_rle_expander.sv
module coef_rle_expander
  import rle_pkg::*;
#(
  parameter int DW      = 8,
  parameter int BLK_DIM = 8,
  parameter int GRP_W   = 4,
  parameter int MB_W    = 6,
  parameter int Q_W     = 5,
  parameter int SUB_W   = 3,
  localparam int NCOEF  = BLK_DIM * BLK_DIM
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [3:0]          mode_i,
  input  logic [DW-1:0]       data_i,
  output logic [GRP_W-1:0]    grp_num_o,
  output logic [MB_W-1:0]     mb_num_o,
  output logic [Q_W-1:0]      quant_o,
  output logic [DW-1:0]       mv_x_o,
  output logic [DW-1:0]       mv_y_o,
  output logic [SUB_W-1:0]    sub_num_o,
  output logic                fixed_mb_o,
  output logic                inter_o,
  output logic                filter_o,
  output logic                mc_o,
  output logic                skip_o,
  output logic                frame_first_o,
  output logic                blk_ready_o,
  output logic [SUB_W-1:0]    blk_sub_o,
  output logic [NCOEF*DW-1:0] blk_coef_o,
  output logic                run_err_o
);

  tag_stb_t stb;

  tag_decoder u_dec (
    .in_valid_i (in_valid_i),
    .mode_i     (mode_i),
    .skip_i     (skip_o),
    .stb_o      (stb)
  );

  hdr_regs #(
    .DW(DW), .GRP_W(GRP_W), .MB_W(MB_W), .Q_W(Q_W), .SUB_W(SUB_W)
  ) u_hdr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stb_i         (stb),
    .data_i        (data_i),
    .grp_num_o     (grp_num_o),
    .mb_num_o      (mb_num_o),
    .quant_o       (quant_o),
    .mv_x_o        (mv_x_o),
    .mv_y_o        (mv_y_o),
    .sub_num_o     (sub_num_o),
    .fixed_mb_o    (fixed_mb_o),
    .inter_o       (inter_o),
    .filter_o      (filter_o),
    .mc_o          (mc_o),
    .skip_o        (skip_o),
    .frame_first_o (frame_first_o)
  );

  run_expander #(
    .DW(DW), .BLK_DIM(BLK_DIM), .SUB_W(SUB_W)
  ) u_exp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_stb_i   (stb.ctrl),
    .sub_stb_i   (stb.sub),
    .run_stb_i   (stb.run),
    .lvl_stb_i   (stb.lvl),
    .data_i      (data_i),
    .cur_sub_i   (sub_num_o),
    .blk_ready_o (blk_ready_o),
    .blk_sub_o   (blk_sub_o),
    .blk_coef_o  (blk_coef_o),
    .run_err_o   (run_err_o)
  );

endmodule

// File: rtl/coef_rle_expander_chk.sv
module coef_rle_expander_chk #(
  parameter int DW      = 8,
  parameter int BLK_DIM = 8,
  parameter int GRP_W   = 4,
  parameter int MB_W    = 6,
  parameter int Q_W     = 5,
  parameter int SUB_W   = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        in_valid_i,
  input logic [3:0]                  mode_i,
  input logic [DW-1:0]               data_i,
  input logic [GRP_W-1:0]            grp_num_o,
  input logic [MB_W-1:0]             mb_num_o,
  input logic [Q_W-1:0]              quant_o,
  input logic [DW-1:0]               mv_x_o,
  input logic [DW-1:0]               mv_y_o,
  input logic [SUB_W-1:0]            sub_num_o,
  input logic                        fixed_mb_o,
  input logic                        inter_o,
  input logic                        filter_o,
  input logic                        mc_o,
  input logic                        skip_o,
  input logic                        frame_first_o,
  input logic                        blk_ready_o,
  input logic [SUB_W-1:0]            blk_sub_o,
  input logic [BLK_DIM*BLK_DIM*DW-1:0] blk_coef_o,
  input logic                        run_err_o
);

  // R2
  grp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 4'b0000 && !skip_o) |=> grp_num_o == $past(data_i[GRP_W-1:0]));

  // R3
  skip_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 4'b0010) |=> skip_o == $past(data_i[6]));

  // R4
  wait_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i == 4'b1111) |=>
      (!blk_ready_o && $stable(grp_num_o) && $stable(quant_o) && $stable(skip_o)));

  // R5
  skip_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_o && in_valid_i && mode_i != 4'b0010) |=>
      (!blk_ready_o && $stable(grp_num_o) && $stable(mb_num_o) && $stable(sub_num_o)));

  // R6
  frame_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && mode_i == 4'b0010) |=> $stable(frame_first_o));

  // R9
  err_with_blk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_err_o) |-> blk_ready_o);

endmodule

bind coef_rle_expander coef_rle_expander_chk #(
  .DW(DW), .BLK_DIM(BLK_DIM), .GRP_W(GRP_W), .MB_W(MB_W), .Q_W(Q_W), .SUB_W(SUB_W)
) u_chk (.*);

// File: tb/sim_coef_rle_expander.sv
`timescale 1ns/1ps
module sim_coef_rle_expander;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   mode = 4'h0;
  logic [7:0]   data = 8'h0;
  logic [3:0]   grp_num;
  logic [5:0]   mb_num;
  logic [4:0]   quant;
  logic [7:0]   mv_x, mv_y;
  logic [2:0]   sub_num;
  logic         fixed_mb, inter_f, filter_f, mc_f, skip_f, frame_first;
  logic         blk_ready;
  logic [2:0]   blk_sub;
  logic [511:0] blk_coef;
  logic         run_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  coef_rle_expander u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .mode_i(mode), .data_i(data),
    .grp_num_o(grp_num), .mb_num_o(mb_num), .quant_o(quant), .mv_x_o(mv_x), .mv_y_o(mv_y),
    .sub_num_o(sub_num), .fixed_mb_o(fixed_mb), .inter_o(inter_f), .filter_o(filter_f),
    .mc_o(mc_f), .skip_o(skip_f), .frame_first_o(frame_first), .blk_ready_o(blk_ready),
    .blk_sub_o(blk_sub), .blk_coef_o(blk_coef), .run_err_o(run_err)
  );

  // independent scan table: walk anti-diagonals
  int scan_r[64];
  initial begin
    int n;
    n = 0;
    for (int s = 0; s < 15; s++) begin
      if (s % 2 == 0) begin
        for (int r = 7; r >= 0; r--)
          if (s - r >= 0 && s - r < 8) begin scan_r[n] = r * 8 + (s - r); n++; end
      end else begin
        for (int r = 0; r < 8; r++)
          if (s - r >= 0 && s - r < 8) begin scan_r[n] = r * 8 + (s - r); n++; end
      end
    end
  end

  // reference model
  logic [7:0]   m_arr[64];
  int           m_pos = 0;
  bit           m_open = 0;
  bit           m_skip = 0;
  logic [2:0]   m_sub = 0;
  logic [511:0] q_coef[$];
  logic [2:0]   q_sub[$];
  bit           q_err[$];

  task automatic m_clear();
    for (int k = 0; k < 64; k++) m_arr[k] = 8'h0;
    m_pos = 0;
  endtask

  task automatic m_emit(input bit err);
    logic [511:0] f;
    for (int k = 0; k < 64; k++) f[k*8 +: 8] = m_arr[k];
    q_coef.push_back(f);
    q_sub.push_back(m_sub);
    q_err.push_back(err);
    m_clear();
    m_open = 0;
  endtask

  task automatic m_step(input logic [3:0] m, input logic [7:0] d);
    if (!in_valid) return;
    if (m_skip && m != 4'b0010) return;
    case (m)
      4'b0010: begin
        if (m_open) m_emit(0);
        m_clear();
        m_open = 0;
        m_skip = d[6];
      end
      4'b0111: begin
        if (m_open) m_emit(0);
        m_clear();
        m_open = 1;
        m_sub = d[2:0];
      end
      4'b1000: if (m_open) begin
        if (m_pos + d > 64) m_emit(1);
        else if (m_pos + d == 64) m_emit(0);
        else m_pos = m_pos + d;
      end
      4'b1001: if (m_open) begin
        m_arr[scan_r[m_pos]] = d;
        if (m_pos == 63) m_emit(0);
        else m_pos++;
      end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] m, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    mode = m;
    data = d;
    m_step(m, d);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && blk_ready) begin
      n_chk++;
      if (q_coef.size() == 0) begin
        n_bad++;
        $display("FAIL R7/R10: unexpected block sub %0d, expected none", blk_sub);
      end else begin
        logic [511:0] ec;
        logic [2:0]   es;
        bit           ee;
        ec = q_coef.pop_front();
        es = q_sub.pop_front();
        ee = q_err.pop_front();
        if (blk_coef !== ec || blk_sub !== es || run_err !== ee) begin
          n_bad++;
          $display("FAIL R7/R8/R9: block act sub %0d err %0b coef %h, exp sub %0d err %0b coef %h",
                   blk_sub, run_err, blk_coef, es, ee, ec);
        end
      end
    end
  end

  task automatic finish_run();
    n_chk++;
    if (q_coef.size() != 0) begin
      n_bad++;
      $display("FAIL R7/R8: %0d blocks missing, expected 0", q_coef.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 grp", grp_num, 0);
    check("R1 flags", {fixed_mb, inter_f, filter_f, mc_f, skip_f, frame_first}, 0);
    check("R1 ready/err", {blk_ready, run_err}, 0);
    rst_n = 1'b1;

    // R2 header fields
    send(4'b0000, 8'h1A); send(4'b0001, 8'hFF); send(4'b0011, 8'hF7);
    send(4'b0100, 8'hF3); send(4'b0101, 8'h05);
    settle();
    check("R2 grp", grp_num, 4'hA);
    check("R2 mb", mb_num, 6'h3F);
    check("R2 quant", quant, 5'h17);
    check("R2 mv", {mv_x, mv_y}, 16'hF305);

    // R3 control flags, R6 first frame
    send(4'b0010, 8'h0F);
    settle();
    check("R3 flags", {fixed_mb, inter_f, filter_f, mc_f, skip_f}, 5'b11110);
    check("R6 first after reset", frame_first, 1);
    send(4'b0010, 8'h02);
    settle();
    check("R6 later ctrl", frame_first, 0);
    check("R3 inter only", {fixed_mb, inter_f, filter_f, mc_f}, 4'b0100);

    // R4 no-effect codes and idle cycles
    send(4'b1111, 8'h03); send(4'b0110, 8'h3F);
    for (int t = 10; t < 15; t++) send(t[3:0], 8'h55);
    @(negedge clk); mode = 4'b0000; data = 8'h07; in_valid = 1'b0;
    settle();
    check("R4 grp held", grp_num, 4'hA);
    check("R4 sub held", sub_num, 0);

    // R10 levels before any sub-block byte
    send(4'b1001, 8'h11); send(4'b1000, 8'h02);

    // R7 full block of 64 distinct levels
    send(4'b0111, 8'h03);
    settle();
    check("R2 sub", sub_num, 3);
    for (int k = 0; k < 64; k++) send(4'b1001, 8'(k * 3 + 1));
    // R10 extra level after block closed
    send(4'b1001, 8'h77); send(4'b1000, 8'h01);
    settle();

    // R7/R8 runs then early flush by sub-block byte
    send(4'b0111, 8'h04);
    send(4'b1000, 8'd5); send(4'b1001, 8'hFD);
    send(4'b1000, 8'd10); send(4'b1001, 8'h07);
    send(4'b0111, 8'h05);
    // R8 empty block flushed by control byte
    send(4'b0010, 8'h00);
    settle();

    // R9 run ending exactly at 64
    send(4'b0111, 8'h01);
    send(4'b1001, 8'h09); send(4'b1000, 8'd63);
    settle();
    check("R9 exact no err", run_err, 0);

    // R9 overrun
    send(4'b0111, 8'h02);
    send(4'b1000, 8'd60); send(4'b1001, 8'h04); send(4'b1000, 8'd10);
    settle();
    check("R9 err held", run_err, 1);
    send(4'b0111, 8'h00);
    settle();
    check("R9 err cleared", run_err, 0);

    // R5 skip picture
    send(4'b0010, 8'h40);
    settle();
    check("R3 skip set", skip_f, 1);
    send(4'b0000, 8'h05); send(4'b0111, 8'h06); send(4'b1001, 8'h22);
    send(4'b0001, 8'h01);
    settle();
    check("R5 grp frozen", grp_num, 4'hA);
    check("R5 mb frozen", mb_num, 6'h3F);
    check("R5 sub frozen", sub_num, 0);
    send(4'b0010, 8'h00);
    settle();
    check("R5 skip cleared", skip_f, 0);
    check("R6 first after skip", frame_first, 1);

    // R7 a second pattern after skip
    send(4'b0111, 8'h02);
    send(4'b1001, 8'h80); send(4'b1000, 8'd20); send(4'b1001, 8'h7F);
    send(4'b1000, 8'd41); send(4'b1001, 8'hC0);
    settle();
    finish_run();
  end

endmodule